// File: doc/BRIEF.md
# Down-Counting Timer with Watchdog Lock

This block is a 32-bit down counter behind a small register bus. Software programs a start value and a clock divider, then enables counting. Each time the counter arrives at zero it raises a sticky event flag, and the flag can drive an interrupt line. With auto-reload the counter starts again from the programmed value, so events repeat at a fixed rate of clk / ((divider+1) * (start+1)).

The same counter can be turned into a watchdog. Once watchdog mode is on, a zero event sets a separate reset-status flag and raises a reset request output instead of the event flag. Software cannot leave watchdog mode by clearing the mode bit. It must write two fixed key words, in order, to a write-only disable register.

Bus reads are registered. Read data appears one clock after the address is presented, and it reflects the state after any write on the previous edge. Only word-aligned addresses decode.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `wd_rst` are 0.
- R2: The registers are decoded at byte offsets 0x00 (start value, read/write), 0x04 (counter, read-only), 0x08 (control), 0x0C (event flag), 0x10 (reset-status flag) and 0x14 (disable key, write-only, reads 0). In control, bit 0 is run, bit 1 is auto-reload, bit 2 is interrupt enable, bit 3 is watchdog mode and bits 15:8 are the divider. Control reads back as written.
- R3: While run is 1, the counter decrements once every divider+1 clocks. While run is 0, both the counter and the divider phase hold.
- R4: A write to offset 0x00 copies the written value into the counter at once and restarts the divider phase from zero.
- R5: Without auto-reload, a decrement to zero sets bit 0 at 0x0C, and the counter then stays at 0.
- R6: With auto-reload, the decrement step taken while the counter is 0 loads the start value. A full period is therefore start+1 steps, and each arrival at zero sets the event flag.
- R7: Writing 1 to bit 0 of 0x0C clears the event flag. Writing 0 leaves it set.
- R8: `irq` equals the event flag ANDed with interrupt enable. It stays high until the flag is cleared or the enable is dropped.
- R9: In watchdog mode, arrival at zero sets bit 0 at 0x10 and raises `wd_rst`, and it leaves the event flag untouched. Writing 1 to bit 0 of 0x10 clears both the flag and `wd_rst`.
- R10: While watchdog mode is on, a control write with bit 3 at 0 does not clear the mode.
- R11: Watchdog mode clears only when 0x12345678 and then 0x87654321 are written to 0x14 on consecutive writes to that register. Any other value written there restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after the address |
| irq | output | 1 | Timer interrupt |
| wd_rst | output | 1 | Watchdog reset request |

## Verification
The bench freezes the counter after a known number of enabled clocks and reads it back. A divider that is off by one, or a counter that runs while run is 0, gives a different count. It rewrites the start value when the divider phase is not zero, which exposes a design that fails to restart the divider. It also runs an auto-reload wrap that must land on the start value rather than stick at zero. In watchdog mode it tries to clear the mode bit directly, then sends a lone second key, then sends the first key, a wrong word and the second key. A design that accepts any of these would show the mode bit cleared too early. The W1C checks write a 0 before a 1, so a design that clears on any write is caught. The interrupt is sampled cycle by cycle around the zero crossing and also with enable off, so an interrupt that ignores the enable or fires a cycle late is flagged.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_LOAD = 8'h00;
  localparam logic [7:0] OFS_CNT  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_INT  = 8'h0C;
  localparam logic [7:0] OFS_RST  = 8'h10;
  localparam logic [7:0] OFS_DIS  = 8'h14;
  // control field positions
  localparam int CB_EN   = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_IE   = 2;
  localparam int CB_WD   = 3;
  localparam int CB_PRE  = 8;
  // watchdog exit keys
  localparam logic [31:0] WD_KEY1 = 32'h12345678;
  localparam logic [31:0] WD_KEY2 = 32'h87654321;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] phase;

  // >= so a divider lowered below the current phase still wraps at once
  assign tick = en && (phase >= presc);

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else if (en)        phase <= tick ? '0 : phase + 1'b1;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase == '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> $stable(phase));
endmodule

// File: rtl/cdt_down.sv
module cdt_down #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic         auto,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] nxt;

  always_comb begin
    if (cnt == '0) nxt = auto ? reload_val : '0;
    else           nxt = cnt - 1'b1;
  end

  // arrival at zero: a real decrement to 0, or an auto wrap onto a zero start value
  assign hit = tick && !load_we && (nxt == '0) && ((cnt != '0) || auto);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load_we) cnt <= load_val;
    else if (tick)    cnt <= nxt;
  end

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_we) |=> $stable(cnt));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_we && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_we && cnt == '0 && !auto) |=> (cnt == '0));
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load_we |=> (cnt == $past(load_val)));
endmodule

// File: rtl/cdt_unlock.sv
module cdt_unlock #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY1 = '0,
  parameter logic [DATA_W-1:0] KEY2 = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlock
);
  logic armed;

  assign unlock = wr && armed && (wdata == KEY2);

  always_ff @(posedge clk) begin
    if (rst)     armed <= 1'b0;
    else if (wr) armed <= (wdata == KEY1);
  end

  p_arm_r11: assert property (@(posedge clk) disable iff (rst)
    unlock |-> $past(wr && wdata == KEY1) || $past(armed));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wd_rst
);
  logic aligned;
  logic sel_load, sel_cnt, sel_ctrl, sel_int, sel_rst, sel_dis;
  logic [DATA_W-1:0] load_r;
  logic              c_en, c_auto, c_ie, c_wd;
  logic [PRE_W-1:0]  c_pre;
  logic              int_flag, rst_flag;
  logic              tick, hit, unlock;
  logic [DATA_W-1:0] cnt;
  logic              int_nxt, rst_nxt, ie_nxt;
  logic [DATA_W-1:0] ctrl_rd, rd_nxt;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign sel_load = aligned && (bus_addr == OFS_LOAD[ADDR_W-1:0]);
  assign sel_cnt  = aligned && (bus_addr == OFS_CNT[ADDR_W-1:0]);
  assign sel_ctrl = aligned && (bus_addr == OFS_CTRL[ADDR_W-1:0]);
  assign sel_int  = aligned && (bus_addr == OFS_INT[ADDR_W-1:0]);
  assign sel_rst  = aligned && (bus_addr == OFS_RST[ADDR_W-1:0]);
  assign sel_dis  = aligned && (bus_addr == OFS_DIS[ADDR_W-1:0]);

  cdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(c_en), .restart(bus_we && sel_load),
    .presc(c_pre), .tick(tick)
  );

  cdt_down #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_we(bus_we && sel_load),
    .load_val(bus_wdata), .reload_val(load_r), .auto(c_auto),
    .cnt(cnt), .hit(hit)
  );

  cdt_unlock #(.DATA_W(DATA_W), .KEY1(WD_KEY1[DATA_W-1:0]),
               .KEY2(WD_KEY2[DATA_W-1:0])) u_unl (
    .clk(clk), .rst(rst), .wr(bus_we && sel_dis), .wdata(bus_wdata),
    .unlock(unlock)
  );

  // sticky flags: a new event wins over a same-cycle clear
  always_comb begin
    int_nxt = int_flag;
    rst_nxt = rst_flag;
    if (bus_we && sel_int && bus_wdata[0]) int_nxt = 1'b0;
    if (bus_we && sel_rst && bus_wdata[0]) rst_nxt = 1'b0;
    if (hit && !c_wd) int_nxt = 1'b1;
    if (hit &&  c_wd) rst_nxt = 1'b1;
    ie_nxt = (bus_we && sel_ctrl) ? bus_wdata[CB_IE] : c_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_r   <= '0;
      c_en     <= 1'b0;
      c_auto   <= 1'b0;
      c_ie     <= 1'b0;
      c_wd     <= 1'b0;
      c_pre    <= '0;
      int_flag <= 1'b0;
      rst_flag <= 1'b0;
      irq      <= 1'b0;
      wd_rst   <= 1'b0;
    end else begin
      if (bus_we && sel_load) load_r <= bus_wdata;
      if (bus_we && sel_ctrl) begin
        c_en   <= bus_wdata[CB_EN];
        c_auto <= bus_wdata[CB_AUTO];
        c_ie   <= bus_wdata[CB_IE];
        c_pre  <= bus_wdata[CB_PRE +: PRE_W];
        c_wd   <= c_wd | bus_wdata[CB_WD];
      end else if (unlock) begin
        c_wd   <= 1'b0;
      end
      int_flag <= int_nxt;
      rst_flag <= rst_nxt;
      irq      <= int_nxt && ie_nxt;
      wd_rst   <= rst_nxt;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_PRE +: PRE_W] = c_pre;
    ctrl_rd[CB_EN]   = c_en;
    ctrl_rd[CB_AUTO] = c_auto;
    ctrl_rd[CB_IE]   = c_ie;
    ctrl_rd[CB_WD]   = c_wd;
    rd_nxt = '0;
    if (sel_load) rd_nxt = load_r;
    if (sel_cnt)  rd_nxt = cnt;
    if (sel_ctrl) rd_nxt = ctrl_rd;
    if (sel_int)  rd_nxt[0] = int_flag;
    if (sel_rst)  rd_nxt[0] = rst_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (int_flag && c_ie));
  p_wd_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (c_wd && !(bus_we && sel_dis)) |=> c_wd);
  p_exit_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(c_wd) |-> $past(bus_we && sel_dis && bus_wdata == WD_KEY2[DATA_W-1:0]));
  p_wdrst_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst) |-> $past(c_wd));
  p_int_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(int_flag) |-> !$past(c_wd));
endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                         A_INT = 5'h0C, A_RST = 5'h10, A_DIS = 5'h14;
  localparam logic [31:0] K1 = 32'h12345678, K2 = 32'h87654321;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wd_rst;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  cdt_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wd_rst(wd_rst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: compares registered read data in the cycle it is due
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      chk(tag_q[0], bus_rdata, exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(expv);
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wd_rst", {31'b0, wd_rst}, 0);
    rd(A_LOAD, 0, "R1 load");
    rd(A_CNT,  0, "R1 cnt");
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_INT,  0, "R1 int");
    rd(A_RST,  0, "R1 rst");

    // R2 R4 load write and readback
    wr(A_LOAD, 10);
    rd(A_LOAD, 10, "R2 load readback");
    rd(A_CNT, 10, "R4 counter copies load");
    // R3 divider 3: 9 enabled edges -> 3 steps
    wr(A_CTRL, 32'h0201);
    repeat (8) @(posedge clk);
    wr(A_CTRL, 32'h0200);
    rd(A_CNT, 7, "R3 divided count");
    repeat (5) @(posedge clk);
    rd(A_CNT, 7, "R3 hold when stopped");
    rd(A_CTRL, 32'h0200, "R2 ctrl readback");
    // 10 enabled edges -> 3 steps, phase left at 1
    wr(A_CTRL, 32'h0201);
    repeat (9) @(posedge clk);
    wr(A_CTRL, 32'h0200);
    rd(A_CNT, 4, "R3 second run");
    // R4 load restarts phase: 2 edges must not step
    wr(A_LOAD, 10);
    wr(A_CTRL, 32'h0201);
    repeat (1) @(posedge clk);
    wr(A_CTRL, 32'h0200);
    rd(A_CNT, 10, "R4 phase restart");

    // R5 R8 zero event without auto-reload, divider 1
    wr(A_CTRL, 0);
    wr(A_LOAD, 2);
    wr(A_CTRL, 32'h0005);
    @(negedge clk) chk("R8 irq before zero", {31'b0, irq}, 0);
    @(negedge clk) chk("R8 irq one step before", {31'b0, irq}, 0);
    @(negedge clk) chk("R8 irq at zero", {31'b0, irq}, 1);
    repeat (4) @(negedge clk);
    rd(A_CNT, 0, "R5 stays at zero");
    rd(A_INT, 1, "R5 flag set");
    // R7 W1C
    wr(A_INT, 0);
    rd(A_INT, 1, "R7 zero write keeps flag");
    @(negedge clk) chk("R8 irq held", {31'b0, irq}, 1);
    wr(A_INT, 1);
    rd(A_INT, 0, "R7 one write clears");
    @(negedge clk) chk("R8 irq drops on clear", {31'b0, irq}, 0);
    // R8 enable off masks irq
    wr(A_CTRL, 0);
    wr(A_LOAD, 1);
    wr(A_CTRL, 32'h0001);
    repeat (3) @(negedge clk);
    chk("R8 masked irq", {31'b0, irq}, 0);
    rd(A_INT, 1, "R5 flag with enable off");
    wr(A_CTRL, 32'h0004);
    @(negedge clk) chk("R8 irq on enable", {31'b0, irq}, 1);
    wr(A_INT, 1);
    wr(A_CTRL, 0);

    // R6 auto-reload: start 3, divider 2, 10 edges -> 5 steps -> 2
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'h0103);
    repeat (9) @(posedge clk);
    wr(A_CTRL, 32'h0102);
    rd(A_CNT, 2, "R6 wrap to start value");
    rd(A_INT, 1, "R6 flag on wrap");
    wr(A_INT, 1);
    wr(A_CTRL, 0);

    // R9 watchdog event
    wr(A_LOAD, 2);
    wr(A_CTRL, 32'h0009);
    repeat (5) @(posedge clk);
    rd(A_RST, 1, "R9 reset flag set");
    rd(A_INT, 0, "R9 event flag untouched");
    @(negedge clk) chk("R9 wd_rst high", {31'b0, wd_rst}, 1);
    // R10 direct clear ignored
    wr(A_CTRL, 0);
    rd(A_CTRL, 32'h0008, "R10 mode bit sticky");
    // R11 sequence checks
    wr(A_DIS, K2);
    rd(A_CTRL, 32'h0008, "R11 lone second key");
    wr(A_DIS, K1);
    wr(A_DIS, 32'h0);
    wr(A_DIS, K2);
    rd(A_CTRL, 32'h0008, "R11 broken sequence");
    rd(A_DIS, 0, "R11 disable reads zero");
    wr(A_DIS, K1);
    wr(A_DIS, K2);
    rd(A_CTRL, 0, "R11 mode cleared");
    @(negedge clk) chk("R9 wd_rst held", {31'b0, wd_rst}, 1);
    wr(A_RST, 1);
    rd(A_RST, 0, "R9 reset flag cleared");
    @(negedge clk) chk("R9 wd_rst low", {31'b0, wd_rst}, 0);
    // after exit, events go to the event flag
    wr(A_LOAD, 1);
    wr(A_CTRL, 32'h0001);
    repeat (4) @(posedge clk);
    rd(A_INT, 1, "R9 normal event after exit");
    rd(A_RST, 0, "R9 no reset flag after exit");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule